// File: doc/BRIEF.md
# Complement-Retrigger Watchdog Timer

This block is a watchdog timer that software cannot switch off once it has been started. It stays idle after an external reset. The first write to its 8-bit register starts it and sets the period. Every later write must be the bitwise inverse of the value written just before it. A correct inverse write restarts the full period. A late write, or a write of any other value, produces a one-cycle reset pulse on the output.

Counting advances only on cycles where the prescaler's enable input is high. A prescale stage of `PRE_W` bits divides those enabled cycles. An 8-bit period counter is then compared with the value captured on the arming write. A reset-cause flag in bit 0 of the read value goes to 0 when the watchdog fires. It stays 0 through later watchdog resets and returns to 1 only on the external reset.

Top module: `cmpl_watchdog`

## Requirements
- R1: After external reset the block is unarmed, `rdData` reads 8'hFF and `wdRst` is 0. While unarmed, `wdRst` stays 0 whatever `tickEn` does.
- R2: A write while unarmed arms the block and captures n = `wrData`. `wdRst` rises on the clock edge that samples the (n+1)·2^PRE_W-th enabled cycle after the arming write, unless a correct retrigger comes first.
- R3: Cycles with `tickEn` low do not advance the timeout. The period is counted in enabled cycles only.
- R4: While armed, writing the bitwise inverse of the last written value restarts the full period. That written value's inverse becomes the next expected pattern.
- R5: While armed, a write of any value other than the expected pattern raises `wdRst` on the next cycle.
- R6: The arming write counts as the first pattern. Writing the arming value again, instead of its inverse, is a wrong pattern.
- R7: Only the arming write sets the period. Retrigger writes do not change it.
- R8: `rdData[0]` becomes 0 together with the `wdRst` pulse. It stays 0 through further watchdog resets, and only `extRstN` sets it back to 1.
- R9: A watchdog reset returns the block to the unarmed state. Unarmed reads give {7'b1111111, flag}, and a following write arms the block again.
- R10: While armed, `rdData` = {expected[7:1], flag}. Here expected is the inverse of the last written value.
- R11: `wdRst` is high for exactly one clock cycle per watchdog reset.
- R12: A correct retrigger written in the same cycle as the final enabled count wins, and no reset is produced.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| extRstN | input | 1 | External (power-on) reset, active low, asynchronous |
| tickEn | input | 1 | Count enable from the system clock prescaler |
| wrEn | input | 1 | Register write strobe |
| wrData | input | 8 | Register write data |
| rdData | output | 8 | Register read data; bit 0 is the reset-cause flag |
| wdRst | output | 1 | Watchdog reset pulse, one cycle |

## Verification
A corrupted expected pattern shows up as a spurious `wdRst` one cycle after the next correct write. It also appears at once in `rdData[7:1]` while the block is armed. A counter that is off by one or counts disabled cycles moves the `wdRst` edge by at least one cycle against the reference count of enabled cycles. A flag that clears or sets wrongly is visible in `rdData[0]` on the cycle right after the pulse. The bench compares every output on every clock, so any such fault is reported within one cycle of becoming observable.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
  // Strobes issued by the control unit to the datapath, at most one set per cycle
  typedef struct packed {
    logic arm;     // first write: capture period, seed pattern, clear counters
    logic retrig;  // correct inverse write: new pattern, clear counters
    logic fire;    // watchdog reset: clear counters
  } wdtStrobes_t;
endpackage

// File: rtl/wdt_datapath.sv
module wdt_datapath
  import wdt_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int PRE_W  = 16
) (
  input  logic              clk,
  input  logic              extRstN,
  input  wdtStrobes_t       strobes,
  input  logic              armed,
  input  logic              tickEn,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] expectedPat,
  output logic              periodDone
);
  localparam logic [PRE_W-1:0] PRE_LAST = '1;

  logic [PRE_W-1:0]  preCnt;
  logic [DATA_W-1:0] periodCnt;
  logic [DATA_W-1:0] limitVal;
  logic              preWrap;
  logic              clearCnt;

  assign preWrap    = (preCnt == PRE_LAST);
  assign clearCnt   = strobes.arm | strobes.retrig | strobes.fire;
  assign periodDone = armed & tickEn & preWrap & (periodCnt == limitVal);

  // prescale and period counters
  always_ff @(posedge clk or negedge extRstN) begin
    if (!extRstN) begin
      preCnt    <= '0;
      periodCnt <= '0;
    end else if (clearCnt) begin
      preCnt    <= '0;
      periodCnt <= '0;
    end else if (armed && tickEn) begin
      preCnt <= preCnt + 1'b1;
      if (preWrap) periodCnt <= periodCnt + 1'b1;
    end
  end

  // captured period and expected pattern
  always_ff @(posedge clk or negedge extRstN) begin
    if (!extRstN) begin
      limitVal    <= '0;
      expectedPat <= '0;
    end else begin
      if (strobes.arm) limitVal <= wrData;
      if (strobes.arm || strobes.retrig) expectedPat <= ~wrData;
    end
  end
endmodule

// File: rtl/wdt_ctrl.sv
module wdt_ctrl
  import wdt_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              extRstN,
  input  logic              wrEn,
  input  logic [DATA_W-1:0] wrData,
  input  logic [DATA_W-1:0] expectedPat,
  input  logic              periodDone,
  output wdtStrobes_t       strobes,
  output logic              armed,
  output logic              causeN,
  output logic              wdRst
);
  logic patMatch;

  assign patMatch = (wrData == expectedPat);

  always_comb begin
    strobes        = '0;
    strobes.arm    = wrEn & ~armed;
    strobes.retrig = wrEn & armed & patMatch;
    // a correct write outranks a timeout in the same cycle
    strobes.fire   = armed & ((wrEn & ~patMatch) | (~wrEn & periodDone));
  end

  always_ff @(posedge clk or negedge extRstN) begin
    if (!extRstN) begin
      armed  <= 1'b0;
      causeN <= 1'b1;
      wdRst  <= 1'b0;
    end else begin
      wdRst <= strobes.fire;
      if (strobes.fire) begin
        armed  <= 1'b0;
        causeN <= 1'b0;
      end else if (strobes.arm) begin
        armed <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/cmpl_watchdog.sv
module cmpl_watchdog
  import wdt_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int PRE_W  = 16
) (
  input  logic              clk,
  input  logic              extRstN,
  input  logic              tickEn,
  input  logic              wrEn,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData,
  output logic              wdRst
);
  wdtStrobes_t       strobes;
  logic              armed;
  logic              causeN;
  logic              periodDone;
  logic [DATA_W-1:0] expectedPat;

  wdt_ctrl #(.DATA_W(DATA_W)) u_ctrl (
    .clk        (clk),
    .extRstN    (extRstN),
    .wrEn       (wrEn),
    .wrData     (wrData),
    .expectedPat(expectedPat),
    .periodDone (periodDone),
    .strobes    (strobes),
    .armed      (armed),
    .causeN     (causeN),
    .wdRst      (wdRst)
  );

  wdt_datapath #(.DATA_W(DATA_W), .PRE_W(PRE_W)) u_dp (
    .clk        (clk),
    .extRstN    (extRstN),
    .strobes    (strobes),
    .armed      (armed),
    .tickEn     (tickEn),
    .wrData     (wrData),
    .expectedPat(expectedPat),
    .periodDone (periodDone)
  );

  assign rdData = armed ? {expectedPat[DATA_W-1:1], causeN}
                        : {{(DATA_W-1){1'b1}}, causeN};
endmodule

// File: rtl/cmpl_watchdog_chk.sv
module cmpl_watchdog_chk #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              extRstN,
  input logic              tickEn,
  input logic              wrEn,
  input logic [DATA_W-1:0] wrData,
  input logic [DATA_W-1:0] rdData,
  input logic              wdRst,
  input logic              armed,
  input logic [DATA_W-1:0] expectedPat
);
  p_pulse_one_r11: assert property (@(posedge clk) disable iff (!extRstN)
    wdRst |=> !wdRst);

  p_wrong_pat_r5: assert property (@(posedge clk) disable iff (!extRstN)
    (armed && wrEn && wrData != expectedPat) |=> wdRst);

  p_arm_r2: assert property (@(posedge clk) disable iff (!extRstN)
    (!armed && wrEn) |=> (armed && !wdRst));

  p_new_pat_r4: assert property (@(posedge clk) disable iff (!extRstN)
    (armed && wrEn && wrData == expectedPat) |=> (armed && !wdRst && expectedPat == ~$past(wrData)));

  p_no_tick_r3: assert property (@(posedge clk) disable iff (!extRstN)
    (armed && !tickEn && !wrEn) |=> !wdRst);

  p_flag_sticky_r8: assert property (@(posedge clk) disable iff (!extRstN)
    !rdData[0] |=> !rdData[0]);

  p_flag_clear_r8: assert property (@(posedge clk) disable iff (!extRstN)
    wdRst |-> !rdData[0]);

  p_disarm_r9: assert property (@(posedge clk) disable iff (!extRstN)
    wdRst |-> (!armed && rdData[DATA_W-1:1] == '1));

  p_idle_r1: assert property (@(posedge clk) disable iff (!extRstN)
    (!armed && !wrEn) |=> !wdRst);

  p_tick_unused: assert property (@(posedge clk) disable iff (!extRstN)
    (!armed && !wrEn && tickEn) |=> !armed);
endmodule

bind cmpl_watchdog cmpl_watchdog_chk #(.DATA_W(DATA_W)) u_chk (
  .clk        (clk),
  .extRstN    (extRstN),
  .tickEn     (tickEn),
  .wrEn       (wrEn),
  .wrData     (wrData),
  .rdData     (rdData),
  .wdRst      (wdRst),
  .armed      (armed),
  .expectedPat(expectedPat)
);

// File: tb/tb_cmpl_watchdog.sv
module tb_cmpl_watchdog;
  localparam int PRE_W = 4;
  localparam int PER   = 1 << PRE_W;
  localparam int MAX_CYC = 150000;

  logic       clk = 1'b0;
  logic       extRstN = 1'b0;
  logic       tickEn = 1'b0;
  logic       wrEn = 1'b0;
  logic [7:0] wrData = 8'h00;
  logic [7:0] rdData;
  logic       wdRst;

  int nChk = 0;
  int nFail = 0;
  int cycCnt = 0;

  // reference model state
  bit       mArmed = 0;
  bit [7:0] mExp = 0;
  int       mLim = 0;
  int       mCnt = 0;
  bit       mFlag = 1;
  bit       mRst = 0;

  cmpl_watchdog #(.DATA_W(8), .PRE_W(PRE_W)) dut (
    .clk(clk), .extRstN(extRstN), .tickEn(tickEn), .wrEn(wrEn),
    .wrData(wrData), .rdData(rdData), .wdRst(wdRst)
  );

  always #5 clk = ~clk;

  function automatic bit [7:0] mRead();
    return mArmed ? {mExp[7:1], mFlag} : {7'h7F, mFlag};
  endfunction

  task automatic check(input string tag, input int got, input int exp);
    nChk++;
    if (got != exp) begin
      nFail++;
      $display("FAIL %s actual=%0h expected=%0h t=%0t", tag, got, exp, $time);
    end
  endtask

  task automatic finishRun();
    $display("%0d/%0d checks passed", nChk - nFail, nChk);
    $finish;
  endtask

  always @(posedge clk) begin
    cycCnt++;
    if (cycCnt > MAX_CYC) begin
      nChk++; nFail++;
      $display("FAIL R1 watchdog expired actual=%0d expected<=%0d", cycCnt, MAX_CYC);
      finishRun();
    end
  end

  task automatic modelEdge();
    bit fire;
    fire = 0;
    if (!extRstN) begin
      mArmed = 0; mExp = 0; mLim = 0; mCnt = 0; mFlag = 1; mRst = 0;
    end else begin
      if (wrEn && !mArmed) begin
        mArmed = 1; mLim = int'(wrData); mExp = ~wrData; mCnt = 0;
      end else if (wrEn && mArmed) begin
        if (wrData == mExp) begin mExp = ~wrData; mCnt = 0; end
        else fire = 1;
      end else if (mArmed && tickEn) begin
        if (mCnt + 1 == (mLim + 1) * PER) fire = 1;
        else mCnt++;
      end
      if (fire) begin mArmed = 0; mCnt = 0; mFlag = 0; end
      mRst = fire;
    end
  endtask

  // one clock: drive at negedge, model at posedge, compare at next negedge
  task automatic step(input bit we, input bit [7:0] d, input bit te);
    wrEn = we; wrData = d; tickEn = te;
    @(posedge clk);
    modelEdge();
    @(negedge clk);
    check("model wdRst", int'(wdRst), int'(mRst));
    check("model rdData", int'(rdData), int'(mRead()));
  endtask

  // run with no writes until wdRst or max cycles; altTick gives tickEn on odd cycles only
  task automatic runToFire(input bit altTick, input int maxCyc,
                           output int ticks, output int cycles, output bit fired);
    ticks = 0; cycles = 0; fired = 0;
    for (int i = 0; i < maxCyc; i++) begin
      bit te;
      te = altTick ? bit'(i % 2) : 1'b1;
      step(0, 8'h00, te);
      cycles++;
      if (te) ticks++;
      if (wdRst) begin fired = 1; break; end
    end
  endtask

  task automatic idle(input int n, input bit te);
    for (int i = 0; i < n; i++) step(0, 8'h00, te);
  endtask

  initial begin
    int tk, cy;
    bit fd;
    repeat (3) @(negedge clk);
    extRstN = 1'b1;
    @(negedge clk);
    // R1: reset state and unarmed idling
    check("R1 reset rdData", int'(rdData), 8'hFF);
    check("R1 reset wdRst", int'(wdRst), 0);
    runToFire(0, 40, tk, cy, fd);
    check("R1 no fire while unarmed", int'(fd), 0);

    // R2: n=2 gives 3*PER enabled cycles
    step(1, 8'h02, 1);
    check("R10 armed read", int'(rdData), int'({8'hFD & 8'hFE} | 8'h01));
    runToFire(0, 200, tk, cy, fd);
    check("R2 fired", int'(fd), 1);
    check("R2 period ticks", tk, 3 * PER);
    check("R8 flag cleared", int'(rdData[0]), 0);
    check("R9 unarmed read", int'(rdData), 8'hFE);
    step(0, 8'h00, 1);
    check("R11 pulse width", int'(wdRst), 0);

    // R3: only enabled cycles count; long stall with tickEn low
    step(1, 8'h00, 1);
    idle(100, 0);
    check("R3 stalled no fire", int'(wdRst), 0);
    runToFire(1, 200, tk, cy, fd);
    check("R3 fired", int'(fd), 1);
    check("R3 enabled ticks", tk, PER);
    check("R3 total cycles", cy, 2 * PER);

    // R4/R7/R10: arm 0xA5 (n=0xA5 long) - use n=1 value via inverse pair 0x01/0xFE
    step(1, 8'h01, 1);
    idle(25, 1);
    step(1, 8'hFE, 1);               // R4 correct inverse
    check("R4 no reset on inverse", int'(wdRst), 0);
    check("R10 read after retrigger", int'(rdData), 8'h00);  // expected 0x01, flag 0
    idle(20, 1);
    step(1, 8'h01, 1);               // R4 next inverse
    check("R4 second retrigger", int'(wdRst), 0);
    runToFire(0, 200, tk, cy, fd);
    check("R7 period unchanged", tk, 2 * PER);

    // R6: rewriting the arming value is wrong
    step(1, 8'h33, 1);
    step(1, 8'h33, 1);
    check("R6 repeat arming value fires", int'(wdRst), 1);
    check("R9 disarmed", int'(rdData), 8'hFE);

    // R5: arbitrary wrong value
    step(1, 8'h10, 0);
    idle(3, 0);
    step(1, 8'h00, 0);
    check("R5 wrong pattern fires", int'(wdRst), 1);
    step(0, 8'h00, 0);
    check("R11 single cycle", int'(wdRst), 0);

    // R12: correct write on the final enabled count
    step(1, 8'h00, 1);
    idle(PER - 1, 1);
    step(1, 8'hFF, 1);
    check("R12 retrigger wins", int'(wdRst), 0);
    runToFire(0, 200, tk, cy, fd);
    check("R12 full period after", tk, PER);

    // R8: only external reset restores the flag
    check("R8 flag still 0", int'(rdData[0]), 0);
    @(negedge clk);
    extRstN = 1'b0;
    step(0, 8'h00, 0);
    extRstN = 1'b1;
    step(0, 8'h00, 0);
    check("R8 flag restored", int'(rdData), 8'hFF);
    check("R1 wdRst after ext reset", int'(wdRst), 0);

    finishRun();
  end
endmodule